// File: doc/BRIEF.md
# Mixed-Width Float Multiply-Accumulate Element

This block is one processing element of a 3×3 convolution array. Every cycle it takes one narrow floating-point activation and one narrow floating-point weight and multiplies them. It adds the product into an accumulator held in a slightly wider custom float, and when a term is flagged as the last of a window, it rounds the accumulated value back to the narrow data-path format. The activation is registered and passed on to the element on the right. The weight is registered and passed on to the element below, so each hop adds one cycle of skew between neighbours.

The narrow data word is 10 bits: sign, 6-bit biased exponent and 3-bit fraction. The wide accumulator word is 12 bits: sign, the same 6-bit exponent and a 5-bit fraction. The bias is 31. A zero exponent field means zero, so there are no subnormals, infinities or NaNs. The element applies no rounding inside the accumulation loop. Products and alignment shifts truncate. Round-to-nearest-even is used only on the final narrowing.

Top module: `mxf_pe`

## Requirements
- R1: `actOut` and `wgtOut` equal the values of `actIn` and `wgtIn` sampled at the previous rising edge, and are zero after reset.
- R2: A narrow word is laid out as {sign[9], exponent[8:3], fraction[2:0]} and a wide word as {sign[11], exponent[10:5], fraction[4:0]}. Both use bias 31. Any operand whose exponent field is 0 counts as zero, whatever its fraction bits.
- R3: The product of two nonzero operands has sign equal to the XOR of the operand signs and exponent ea+ew-31, plus 1 if the 8-bit significand product is at least 2.0. Its fraction is the exact significand product truncated to 5 fraction bits. A product exponent below 1 gives an all-zero product.
- R4: A term presented with `clrAcc` high loads its own product into the accumulator and discards the previous sum. A term presented with `clrAcc` low is added to the sum.
- R5: On addition, the operand of smaller magnitude has its significand shifted right by the exponent difference. Bits that fall below the larger operand's fraction LSB are discarded. The signed sum is then normalised, and bits below the 5-bit fraction are truncated.
- R6: After an effective subtraction, the result is renormalised by a left shift equal to its leading-zero count. An exact-zero sum, or a result exponent below 1, becomes the all-zero word.
- R7: An exponent above 63, whether in the product, the sum or the narrowing, saturates to the largest finite magnitude with the result's sign: exponent 63 with all fraction bits set.
- R8: Narrowing keeps the top 3 fraction bits and rounds to nearest with ties to even. A fraction carry increments the exponent, and a zero accumulator narrows to the zero word.
- R9: If `lastTerm` is high at rising edge k, `psumValid` is high for exactly the cycle after edge k+3. At that point `psumOut` holds the narrowed sum including that term. `psumOut` holds its value while no narrowing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| actIn | input | 10 | Activation operand from the left neighbour |
| wgtIn | input | 10 | Weight operand from the upper neighbour |
| clrAcc | input | 1 | Term starts a new window: load instead of add |
| lastTerm | input | 1 | Term closes the window: narrow and emit the sum |
| actOut | output | 10 | Registered activation to the right neighbour |
| wgtOut | output | 10 | Registered weight to the lower neighbour |
| psumOut | output | 10 | Narrowed partial sum |
| psumValid | output | 1 | One-cycle strobe marking a new `psumOut` |

## Verification
The assertions rely on reset being held for at least one edge with `lastTerm` and `clrAcc` low. They also rely on operands entering as encoded words whose meaning is fixed by the exponent field alone. The stimulus keeps to this by applying reset with all inputs zero, and by starting every window with a clear strobe so that no stale sum from the free-running accumulator reaches a checked result. It deliberately sends zero-exponent words with nonzero fraction bits, and it mixes exponents near the bias with full-range words so that underflow, cancellation and saturation are all reached.

// File: rtl/mxf_pkg.sv
package mxf_pkg;

  // Default format: 6-bit exponent, 3-bit narrow fraction, 5-bit wide fraction
  localparam int DEF_EXP_W  = 6;
  localparam int DEF_NMAN_W = 3;
  localparam int DEF_WMAN_W = 5;

  // Strobes handed from the control pipeline to the datapath
  typedef struct packed {
    logic accLoad;     // product replaces the accumulator
    logic narrowFire;  // accumulator is narrowed onto psumOut
  } mxf_strobe_t;

endpackage

// File: rtl/mxf_lzc.sv
module mxf_lzc #(
  parameter  int WIDTH = 6,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [CNT_W-1:0] zeroCnt
);

  // Highest set bit wins because the loop runs upward
  always_comb begin
    zeroCnt = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) zeroCnt = CNT_W'(WIDTH - 1 - i);
    end
  end

endmodule

// File: rtl/mxf_ctrl.sv
module mxf_ctrl
  import mxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrAcc,
  input  logic        lastTerm,
  output mxf_strobe_t strobe
);

  // Stage 1 tracks the operand registers, stage 2 the product register,
  // stage 3 the accumulator register.
  logic clrS1, clrS2;
  logic lastS1, lastS2, lastS3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrS1  <= 1'b0;
      clrS2  <= 1'b0;
      lastS1 <= 1'b0;
      lastS2 <= 1'b0;
      lastS3 <= 1'b0;
    end else begin
      clrS1  <= clrAcc;
      clrS2  <= clrS1;
      lastS1 <= lastTerm;
      lastS2 <= lastS1;
      lastS3 <= lastS2;
    end
  end

  assign strobe.accLoad    = clrS2;
  assign strobe.narrowFire = lastS3;

endmodule

// File: rtl/mxf_datapath.sv
module mxf_datapath
  import mxf_pkg::*;
#(
  parameter  int EXP_W  = DEF_EXP_W,
  parameter  int NMAN_W = DEF_NMAN_W,
  parameter  int WMAN_W = DEF_WMAN_W,
  localparam int NW     = 1 + EXP_W + NMAN_W,
  localparam int WW     = 1 + EXP_W + WMAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NW-1:0] actIn,
  input  logic [NW-1:0] wgtIn,
  input  mxf_strobe_t   strobe,
  output logic [NW-1:0] actOut,
  output logic [NW-1:0] wgtOut,
  output logic [NW-1:0] psumOut,
  output logic          psumValid
);

  localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
  localparam int EMAX   = (2 ** EXP_W) - 1;
  localparam int PSIG_W = 2 * (NMAN_W + 1);
  localparam int SIG_W  = WMAN_W + 1;
  localparam int ASIG_W = WMAN_W + 2;
  localparam int XE_W   = EXP_W + 3;
  localparam int DROP   = WMAN_W - NMAN_W;
  localparam int LZ_W   = $clog2(SIG_W + 1);
  localparam logic signed [XE_W-1:0] EMAX_S = XE_W'(EMAX);
  localparam logic signed [XE_W-1:0] ONE_S  = XE_W'(1);

  // ---------------- registers ----------------
  logic [NW-1:0] actQ, wgtQ;
  logic [WW-1:0] prodQ, accQ;
  logic [NW-1:0] psumQ;
  logic          psumValidQ;
  logic [1:0]    warmCnt;

  // ---------------- multiply ----------------
  logic              aSign, pSign;
  logic [EXP_W-1:0]  aExp, wExp;
  logic [PSIG_W-1:0] prodSig, prodNorm;
  logic              prodTop;
  logic signed [XE_W-1:0] prodExp;
  logic [WMAN_W-1:0] prodFrac;
  logic [WW-1:0]     prodWord;
  logic              unusedProdBits;

  assign aSign = actQ[NW-1];
  assign aExp  = actQ[NW-2 -: EXP_W];
  assign wExp  = wgtQ[NW-2 -: EXP_W];

  always_comb begin
    pSign    = aSign ^ wgtQ[NW-1];
    prodSig  = PSIG_W'({1'b1, actQ[NMAN_W-1:0]}) * PSIG_W'({1'b1, wgtQ[NMAN_W-1:0]});
    prodTop  = prodSig[PSIG_W-1];
    prodNorm = prodTop ? prodSig : (prodSig << 1);
    prodFrac = prodNorm[PSIG_W-2 -: WMAN_W];
    prodExp  = XE_W'(aExp) + XE_W'(wExp) - XE_W'(BIAS) + XE_W'(prodTop);
    if (aExp == '0 || wExp == '0 || prodExp < ONE_S) begin
      prodWord = '0;
    end else if (prodExp > EMAX_S) begin
      prodWord = {pSign, {EXP_W{1'b1}}, {WMAN_W{1'b1}}};
    end else begin
      prodWord = {pSign, prodExp[EXP_W-1:0], prodFrac};
    end
  end

  assign unusedProdBits = ^{prodNorm[PSIG_W-1], prodNorm[PSIG_W-2-WMAN_W:0]};

  // ---------------- align and add ----------------
  logic              accBig, effSub;
  logic [WW-1:0]     bigW, smlW;
  logic [EXP_W-1:0]  bigE, smlE, expDiff;
  logic [SIG_W-1:0]  bigSig, smlSig, smlAln;
  logic [ASIG_W-1:0] rawSum;
  logic [LZ_W-1:0]   lzCnt;
  logic [SIG_W-1:0]  normSh;
  logic signed [XE_W-1:0] sumExp;
  logic [WMAN_W-1:0] sumFrac;
  logic [WW-1:0]     sumWord;
  logic              unusedNormBit;

  always_comb begin
    accBig  = accQ[WW-2:0] >= prodQ[WW-2:0];
    bigW    = accBig ? accQ : prodQ;
    smlW    = accBig ? prodQ : accQ;
    bigE    = bigW[WW-2 -: EXP_W];
    smlE    = smlW[WW-2 -: EXP_W];
    bigSig  = (bigE == '0) ? '0 : {1'b1, bigW[WMAN_W-1:0]};
    smlSig  = (smlE == '0) ? '0 : {1'b1, smlW[WMAN_W-1:0]};
    expDiff = bigE - smlE;
    smlAln  = smlSig >> expDiff;
    effSub  = bigW[WW-1] ^ smlW[WW-1];
    rawSum  = effSub ? (ASIG_W'(bigSig) - ASIG_W'(smlAln))
                     : (ASIG_W'(bigSig) + ASIG_W'(smlAln));
  end

  mxf_lzc #(.WIDTH(SIG_W)) u_lzc (
    .vecIn  (rawSum[SIG_W-1:0]),
    .zeroCnt(lzCnt)
  );

  always_comb begin
    normSh = rawSum[SIG_W-1:0] << lzCnt;
    if (rawSum[ASIG_W-1]) begin
      sumExp  = XE_W'(bigE) + ONE_S;
      sumFrac = rawSum[WMAN_W:1];
    end else begin
      sumExp  = XE_W'(bigE) - XE_W'(lzCnt);
      sumFrac = normSh[WMAN_W-1:0];
    end
    if (rawSum == '0 || sumExp < ONE_S) begin
      sumWord = '0;
    end else if (sumExp > EMAX_S) begin
      sumWord = {bigW[WW-1], {EXP_W{1'b1}}, {WMAN_W{1'b1}}};
    end else begin
      sumWord = {bigW[WW-1], sumExp[EXP_W-1:0], sumFrac};
    end
  end

  assign unusedNormBit = normSh[SIG_W-1];

  // ---------------- narrowing ----------------
  logic [EXP_W-1:0]  accE;
  logic [NMAN_W-1:0] keepBits;
  logic              rndBit, stickyBit, roundUp;
  logic [NMAN_W:0]   keepInc;
  logic signed [XE_W-1:0] nExp;
  logic [NW-1:0]     narrowWord;

  assign accE     = accQ[WW-2 -: EXP_W];
  assign keepBits = accQ[WMAN_W-1 -: NMAN_W];
  assign rndBit   = accQ[DROP-1];

  generate
    if (DROP >= 2) begin : g_sticky
      assign stickyBit = |accQ[DROP-2:0];
    end else begin : g_nosticky
      assign stickyBit = 1'b0;
    end
  endgenerate

  always_comb begin
    roundUp = rndBit & (stickyBit | keepBits[0]);
    keepInc = {1'b0, keepBits} + {{NMAN_W{1'b0}}, roundUp};
    nExp    = XE_W'(accE) + XE_W'(keepInc[NMAN_W]);
    if (accE == '0) begin
      narrowWord = '0;
    end else if (nExp > EMAX_S) begin
      narrowWord = {accQ[WW-1], {EXP_W{1'b1}}, {NMAN_W{1'b1}}};
    end else begin
      narrowWord = {accQ[WW-1], nExp[EXP_W-1:0], keepInc[NMAN_W-1:0]};
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ       <= '0;
      wgtQ       <= '0;
      prodQ      <= '0;
      accQ       <= '0;
      psumQ      <= '0;
      psumValidQ <= 1'b0;
      warmCnt    <= '0;
    end else begin
      actQ       <= actIn;
      wgtQ       <= wgtIn;
      prodQ      <= prodWord;
      accQ       <= strobe.accLoad ? prodQ : sumWord;
      if (strobe.narrowFire) psumQ <= narrowWord;
      psumValidQ <= strobe.narrowFire;
      if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
    end
  end

  assign actOut    = actQ;
  assign wgtOut    = wgtQ;
  assign psumOut   = psumQ;
  assign psumValid = psumValidQ;

  // ---------------- assertions ----------------
  p_fwd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt != 2'd0) |-> (actOut == $past(actIn) && wgtOut == $past(wgtIn)));

  p_acc_zero_canon_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accQ[WW-2 -: EXP_W] == '0) |-> (accQ == '0));

  p_psum_zero_canon_r6: assert property (@(posedge clk) disable iff (!rstN)
    (psumValid && psumOut[NW-2 -: EXP_W] == '0) |-> (psumOut == '0));

  p_add_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accLoad && prodQ == '0) |=> (accQ == $past(accQ)));

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accLoad && accQ[WW-2:0] == {WW-1{1'b1}} && prodQ[WW-1] == accQ[WW-1])
      |=> (accQ == $past(accQ)));

  p_psum_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.narrowFire) |=> $stable(psumOut));

endmodule

// File: rtl/mxf_pe.sv
module mxf_pe
  import mxf_pkg::*;
#(
  parameter  int EXP_W  = DEF_EXP_W,
  parameter  int NMAN_W = DEF_NMAN_W,
  parameter  int WMAN_W = DEF_WMAN_W,
  localparam int NW     = 1 + EXP_W + NMAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NW-1:0] actIn,
  input  logic [NW-1:0] wgtIn,
  input  logic          clrAcc,
  input  logic          lastTerm,
  output logic [NW-1:0] actOut,
  output logic [NW-1:0] wgtOut,
  output logic [NW-1:0] psumOut,
  output logic          psumValid
);

  mxf_strobe_t strobe;

  mxf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clrAcc  (clrAcc),
    .lastTerm(lastTerm),
    .strobe  (strobe)
  );

  mxf_datapath #(
    .EXP_W (EXP_W),
    .NMAN_W(NMAN_W),
    .WMAN_W(WMAN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .actIn    (actIn),
    .wgtIn    (wgtIn),
    .strobe   (strobe),
    .actOut   (actOut),
    .wgtOut   (wgtOut),
    .psumOut  (psumOut),
    .psumValid(psumValid)
  );

  // End-to-end latency of the result strobe
  logic [2:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 3'd4) warmCnt <= warmCnt + 3'd1;
  end

  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 3'd4) |-> (psumValid == $past(lastTerm, 4)));

endmodule

// File: tb/mxf_pe_tb.sv
module mxf_pe_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] actIn = '0, wgtIn = '0;
  logic       clrAcc = 1'b0, lastTerm = 1'b0;
  logic [9:0] actOut, wgtOut, psumOut;
  logic       psumValid;

  always #4 clk = ~clk;  // 125 MHz

  mxf_pe u_dut (
    .clk(clk), .rstN(rstN), .actIn(actIn), .wgtIn(wgtIn),
    .clrAcc(clrAcc), .lastTerm(lastTerm),
    .actOut(actOut), .wgtOut(wgtOut), .psumOut(psumOut), .psumValid(psumValid)
  );

  int vecCnt = 0, errCnt = 0, cyc = 0;
  bit finished = 1'b0;
  logic       expV [8];
  logic [9:0] expD [8];
  string      expT [8];
  logic [9:0] prevAct = '0, prevWgt = '0;
  logic [11:0] mAcc = '0;
  logic [31:0] rng = 32'h1234_abcd;

  // ---- reference arithmetic, written from the requirements ----
  function automatic logic [11:0] mulModel(input logic [9:0] a, input logic [9:0] w);
    int ea, ew, sig, e, fr;
    logic s;
    ea = a[8:3];
    ew = w[8:3];
    if (ea == 0 || ew == 0) return 12'h000;          // R2
    s   = a[9] ^ w[9];
    sig = (8 + a[2:0]) * (8 + w[2:0]);               // value sig/64
    e   = ea + ew - 31;
    if (sig >= 128) begin e = e + 1; fr = (sig / 4) % 32; end
    else fr = (sig / 2) % 32;
    if (e < 1) return 12'h000;                       // R3 underflow
    if (e > 63) return {s, 11'h7FF};                 // R7
    return {s, 6'(e), 5'(fr)};
  endfunction

  function automatic logic [11:0] addModel(input logic [11:0] x, input logic [11:0] y);
    logic [11:0] b, t;
    int be, te, bs, ts, sum, e;
    if (x[10:0] >= y[10:0]) begin b = x; t = y; end else begin b = y; t = x; end
    be = b[10:5];
    te = t[10:5];
    bs = (be == 0) ? 0 : 32 + b[4:0];
    ts = (te == 0) ? 0 : ((32 + t[4:0]) >> (be - te));
    sum = (b[11] != t[11]) ? bs - ts : bs + ts;
    if (sum == 0) return 12'h000;                    // R6
    e = be;
    if (sum >= 64) begin sum = sum / 2; e = e + 1; end
    while (sum < 32) begin sum = sum * 2; e = e - 1; end
    if (e < 1) return 12'h000;
    if (e > 63) return {b[11], 11'h7FF};
    return {b[11], 6'(e), 5'(sum % 32)};
  endfunction

  function automatic logic [9:0] narrowModel(input logic [11:0] x);
    int e, keep, r, st;
    e = x[10:5];
    if (e == 0) return 10'h000;
    keep = x[4:2];
    r    = x[1];
    st   = x[0];
    if (r == 1 && (st == 1 || (keep % 2) == 1)) keep = keep + 1;   // R8
    if (keep == 8) begin keep = 0; e = e + 1; end
    if (e > 63) return {x[11], 9'h1FF};
    return {x[11], 6'(e), 3'(keep)};
  endfunction

  function automatic logic [9:0] pick();
    logic [31:0] r;
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
    if (r[25:24] == 2'b00) return r[9:0];
    return {r[20], 6'(27 + (r[7:1] % 9)), r[12:10]};
  endfunction

  // ---- one cycle: check outputs, then drive the next term ----
  task automatic step(input logic [9:0] a, input logic [9:0] w,
                      input logic c, input logic l, input string tag);
    int slot;
    @(negedge clk);
    slot = cyc % 8;
    vecCnt++;
    if (psumValid !== expV[slot]) begin
      errCnt++;
      $display("FAIL R9 cycle %0d psumValid actual=%b expected=%b", cyc, psumValid, expV[slot]);
    end else if (expV[slot] && psumOut !== expD[slot]) begin
      errCnt++;
      $display("FAIL %s cycle %0d psumOut actual=%h expected=%h", expT[slot], cyc, psumOut, expD[slot]);
    end
    vecCnt++;
    if (actOut !== prevAct || wgtOut !== prevWgt) begin
      errCnt++;
      $display("FAIL R1 cycle %0d forward actual=%h/%h expected=%h/%h",
               cyc, actOut, wgtOut, prevAct, prevWgt);
    end
    expV[slot] = 1'b0;
    actIn = a; wgtIn = w; clrAcc = c; lastTerm = l;
    mAcc = c ? mulModel(a, w) : addModel(mAcc, mulModel(a, w));   // R4 R5
    if (l) begin
      expV[(cyc + 4) % 8] = 1'b1;
      expD[(cyc + 4) % 8] = narrowModel(mAcc);
      expT[(cyc + 4) % 8] = tag;
    end
    prevAct = a; prevWgt = w;
    cyc++;
  endtask

  localparam logic [9:0] ONE  = {1'b0, 6'd31, 3'd0};   // 1.0
  localparam logic [9:0] MAXP = 10'h1FF;

  initial begin
    for (int i = 0; i < 8; i++) begin expV[i] = 1'b0; expD[i] = '0; expT[i] = ""; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R1, R9)
    vecCnt++;
    if (psumValid !== 1'b0 || psumOut !== '0) begin
      errCnt++;
      $display("FAIL R9 reset psum actual=%b/%h expected=0/000", psumValid, psumOut);
    end
    vecCnt++;
    if (actOut !== '0 || wgtOut !== '0) begin
      errCnt++;
      $display("FAIL R1 reset forward actual=%h/%h expected=000/000", actOut, wgtOut);
    end

    // directed corners
    step(10'b0_000000_101, ONE, 1, 1, "R2");             // zero exponent, nonzero fraction
    step({1'b0, 6'd1, 3'd3}, {1'b0, 6'd1, 3'd7}, 1, 1, "R3");  // product underflow
    step(MAXP, MAXP, 1, 1, "R7");                        // product overflow
    step(10'h3FF, MAXP, 1, 1, "R7");                     // negative saturation
    for (int i = 0; i < 6; i++) step({1'b0, 6'd60, 3'd7}, {1'b0, 6'd33, 3'd7}, (i == 0), (i == 5), "R7");
    step({1'b0, 6'd40, 3'd5}, ONE, 1, 0, "R4");
    step({1'b0, 6'd41, 3'd2}, ONE, 0, 0, "R4");
    step({1'b1, 6'd29, 3'd3}, ONE, 1, 1, "R4");          // clear discards old sum
    step({1'b0, 6'd34, 3'd5}, ONE, 1, 0, "R6");
    step({1'b1, 6'd34, 3'd5}, ONE, 0, 1, "R6");          // exact cancellation
    step({1'b0, 6'd31, 3'd4}, ONE, 1, 0, "R6");          // 1.5
    step({1'b1, 6'd31, 3'd2}, ONE, 0, 1, "R6");          // -1.25 -> 0.25
    step({1'b0, 6'd45, 3'd1}, ONE, 1, 0, "R5");
    step({1'b0, 6'd31, 3'd7}, ONE, 0, 1, "R5");          // far smaller addend dropped

    // single-term sweep: every activation against 64 weights
    for (int a = 0; a < 1024; a++) begin
      for (int k = 0; k < 64; k++) begin
        step(10'(a), 10'((k << 4) | ((a * 5 + k) & 15)), 1, 1, "R3 R8");
      end
    end

    // two-term windows
    for (int i = 0; i < 8000; i++) begin
      step(pick(), pick(), 1, 0, "R5");
      step(pick(), pick(), 0, 1, "R5");
    end

    // nine-term windows (3x3 kernel)
    for (int i = 0; i < 1500; i++) begin
      for (int t = 0; t < 9; t++) step(pick(), pick(), (t == 0), (t == 8), "R5 R6");
    end

    // drain
    for (int i = 0; i < 6; i++) step('0, '0, 0, 0, "R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule